// File: doc/BRIEF.md
# Predicate-Writing Compare Unit

This block compares two 64-bit integers and writes the outcome into a pair of 1-bit predicate registers. It holds the 64-entry predicate file itself. Each accepted operation names a guard predicate, two destination predicates, where the left-hand operand comes from, which relation to test, and which write policy to apply.

The left-hand operand is one of three things: the full register value, a sign-extended 8-bit immediate, or zero. Each operand carries a deferred-exception tag. A set tag suppresses or forces the predicate writes, depending on the write policy. If one operation names the same destination twice, it is refused and a fault pulse is raised. Operand fetch, decode and fault handling are left to the surrounding pipeline.

Top module: `pcmp_unit`

## Requirements
- R1: After reset, `pred_o` equals 64'h1 (only predicate 0 set) and `fault_o` is 0.
- R2: Predicate 0 always reads 1. Any write aimed at index 0 is dropped, while the other destination of the same operation is still written.
- R3: The operation raises a fault when `dst_a_idx_i == dst_b_idx_i` and either the guard predicate is 1 or `ctype_i` is 1 (unconditional). On the next clock `fault_o` is 1 and no predicate changes. After any other clock `fault_o` is 0.
- R4: `src_sel_i` picks the left-hand operand: 0 gives `opnd_a_i`, 1 gives `opnd_a_i[7:0]` sign-extended to 64 bits, and 2 or 3 gives zero.
- R5: The effective tag is `tag_b_i OR (tag_a_i AND src_sel_i==0)`. This means `tag_a_i` has no effect in immediate or zero form.
- R6: `rel_i` selects a test of the left operand against `opnd_b_i`, with the left operand always on the left side of the test:
  - 0 is ==, and 1 is !=.
  - 2, 3, 4 and 5 are the signed tests <, <=, > and >=.
  - 6, 7 and 8 are the unsigned tests <, <= and >.
  - 9 through 15 are the unsigned test >=.
- R7: This rule applies with the guard predicate at 1, for `ctype_i` 0 (normal), 1 (unconditional) and 5 to 7 (treated as normal). A set tag clears both destinations. Otherwise destination A gets the relation result and destination B gets its complement.
- R8: For `ctype_i` 2 (and-type) with the guard at 1, both destinations are cleared if the tag is set or the relation is false. Otherwise both are left unchanged.
- R9: For `ctype_i` 3 (or-type) with the guard at 1, both destinations are set to 1 if the tag is clear and the relation is true. Otherwise both are left unchanged.
- R10: For `ctype_i` 4 (or-andcomplement) with the guard at 1, destination A is set to 1 and destination B is cleared if the tag is clear and the relation is true. Otherwise both are left unchanged.
- R11: When the guard predicate is 0, no predicate changes, with one exception: for unconditional type (`ctype_i` 1) both destinations are cleared, subject to the R3 fault check.
- R12: Predicates and `fault_o` change only on a rising clock edge. With `valid_i` low, the predicate file holds and `fault_o` is 0 after the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Operation strobe |
| qp_idx_i | input | 6 | Guard predicate index |
| dst_a_idx_i | input | 6 | Destination A predicate index |
| dst_b_idx_i | input | 6 | Destination B predicate index |
| src_sel_i | input | 2 | Left operand source form |
| rel_i | input | 4 | Relation code |
| ctype_i | input | 3 | Write policy code |
| opnd_a_i | input | 64 | Left register operand (low byte doubles as immediate) |
| opnd_b_i | input | 64 | Right operand |
| tag_a_i | input | 1 | Deferred-exception tag of left operand |
| tag_b_i | input | 1 | Deferred-exception tag of right operand |
| fault_o | output | 1 | Registered illegal-operation pulse |
| pred_o | output | 64 | Predicate file contents |

## Verification
Destination indices are drawn from a narrow range, so equal destinations and index 0 come up often. A design that wrote before checking for a fault, or that skipped the check in unconditional type under a false guard, would change predicates during a fault cycle. Operands are seeded with sign-boundary values and 0xFF immediates. A design that mixed up signed and unsigned tests, or that zero-extended the immediate, would give the wrong relation results. The left-operand tag is toggled in immediate and zero forms, where honouring it would wrongly clear destinations. Or-type and and-type runs check that bits only ever rise or only ever fall.

// File: rtl/pcmp_pkg.sv
package pcmp_pkg;
    localparam int unsigned DATA_W = 64;
    localparam int unsigned NPRED  = 64;
    localparam int unsigned IDX_W  = $clog2(NPRED);
    localparam int unsigned IMM_W  = 8;

    localparam logic [1:0] SRC_REG = 2'd0;
    localparam logic [1:0] SRC_IMM = 2'd1;

    localparam logic [2:0] CT_NORMAL = 3'd0;
    localparam logic [2:0] CT_UNC    = 3'd1;
    localparam logic [2:0] CT_AND    = 3'd2;
    localparam logic [2:0] CT_OR     = 3'd3;
    localparam logic [2:0] CT_ANDCM  = 3'd4;

    typedef struct packed {
        logic [NPRED-1:0] pred;
        logic             fault;
    } pcmp_state_t;

    typedef struct packed {
        logic wr_a;
        logic val_a;
        logic wr_b;
        logic val_b;
    } pcmp_wr_t;
endpackage

// File: rtl/pcmp_relation.sv
module pcmp_relation
    import pcmp_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned IW = IMM_W
) (
    input  logic [1:0]   src_sel_i,
    input  logic [3:0]   rel_i,
    input  logic [W-1:0] opnd_a_i,
    input  logic [W-1:0] opnd_b_i,
    input  logic         tag_a_i,
    input  logic         tag_b_i,
    output logic         rel_true_o,
    output logic         tag_o
);
    logic [W-1:0] lhs;
    logic         s_lt, s_eq, u_lt;

    always_comb begin
        unique case (src_sel_i)
            SRC_REG: lhs = opnd_a_i;
            SRC_IMM: lhs = {{(W-IW){opnd_a_i[IW-1]}}, opnd_a_i[IW-1:0]};
            default: lhs = '0;
        endcase
        tag_o = tag_b_i | (tag_a_i & (src_sel_i == SRC_REG));
        s_eq  = (lhs == opnd_b_i);
        s_lt  = ($signed(lhs) < $signed(opnd_b_i));
        u_lt  = (lhs < opnd_b_i);
        unique case (rel_i)
            4'd0:    rel_true_o = s_eq;
            4'd1:    rel_true_o = !s_eq;
            4'd2:    rel_true_o = s_lt;
            4'd3:    rel_true_o = s_lt | s_eq;
            4'd4:    rel_true_o = !(s_lt | s_eq);
            4'd5:    rel_true_o = !s_lt;
            4'd6:    rel_true_o = u_lt;
            4'd7:    rel_true_o = u_lt | s_eq;
            4'd8:    rel_true_o = !(u_lt | s_eq);
            default: rel_true_o = !u_lt;
        endcase
    end
endmodule

// File: rtl/pcmp_policy.sv
module pcmp_policy
    import pcmp_pkg::*;
(
    input  logic     guard_i,
    input  logic     tag_i,
    input  logic     rel_i,
    input  logic [2:0] ctype_i,
    output pcmp_wr_t wr_o
);
    logic hit;

    always_comb begin
        hit  = !tag_i && rel_i;
        wr_o = '0;
        if (!guard_i) begin
            if (ctype_i == CT_UNC) begin
                wr_o.wr_a = 1'b1;
                wr_o.wr_b = 1'b1;
            end
        end else begin
            unique case (ctype_i)
                CT_AND: begin
                    wr_o.wr_a = !hit;
                    wr_o.wr_b = !hit;
                end
                CT_OR: begin
                    wr_o = '{wr_a: hit, val_a: 1'b1, wr_b: hit, val_b: 1'b1};
                end
                CT_ANDCM: begin
                    wr_o = '{wr_a: hit, val_a: 1'b1, wr_b: hit, val_b: 1'b0};
                end
                default: begin
                    wr_o.wr_a  = 1'b1;
                    wr_o.wr_b  = 1'b1;
                    wr_o.val_a = hit;
                    wr_o.val_b = !tag_i && !rel_i;
                end
            endcase
        end
    end
endmodule

// File: rtl/pcmp_unit.sv
module pcmp_unit
    import pcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [IDX_W-1:0]  qp_idx_i,
    input  logic [IDX_W-1:0]  dst_a_idx_i,
    input  logic [IDX_W-1:0]  dst_b_idx_i,
    input  logic [1:0]        src_sel_i,
    input  logic [3:0]        rel_i,
    input  logic [2:0]        ctype_i,
    input  logic [DATA_W-1:0] opnd_a_i,
    input  logic [DATA_W-1:0] opnd_b_i,
    input  logic              tag_a_i,
    input  logic              tag_b_i,
    output logic              fault_o,
    output logic [NPRED-1:0]  pred_o
);
    localparam logic [NPRED-1:0] PRED_RST = {{(NPRED-1){1'b0}}, 1'b1};

    pcmp_state_t st_d, st_q;
    pcmp_wr_t    wr;
    logic        rel_true, tag_eff, guard, fault_hit;

    pcmp_relation #(.W(DATA_W), .IW(IMM_W)) u_rel (
        .src_sel_i  (src_sel_i),
        .rel_i      (rel_i),
        .opnd_a_i   (opnd_a_i),
        .opnd_b_i   (opnd_b_i),
        .tag_a_i    (tag_a_i),
        .tag_b_i    (tag_b_i),
        .rel_true_o (rel_true),
        .tag_o      (tag_eff)
    );

    pcmp_policy u_pol (
        .guard_i (guard),
        .tag_i   (tag_eff),
        .rel_i   (rel_true),
        .ctype_i (ctype_i),
        .wr_o    (wr)
    );

    always_comb begin
        guard     = st_q.pred[qp_idx_i];
        fault_hit = (dst_a_idx_i == dst_b_idx_i) && (guard || ctype_i == CT_UNC);
        st_d      = st_q;
        st_d.fault = 1'b0;
        if (valid_i) begin
            if (fault_hit) begin
                st_d.fault = 1'b1;
            end else begin
                if (wr.wr_a) st_d.pred[dst_a_idx_i] = wr.val_a;
                if (wr.wr_b) st_d.pred[dst_b_idx_i] = wr.val_b;
            end
        end
        st_d.pred[0] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pred  <= PRED_RST;
            st_q.fault <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pred_o  = st_q.pred;
    assign fault_o = st_q.fault;

    AST_P0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        pred_o[0]); // R2
    AST_FAULT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> $stable(pred_o)); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> ($stable(pred_o) && !fault_o)); // R12
    AST_OR_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ctype_i == CT_OR) |=> (($past(pred_o) & ~pred_o) == '0)); // R9
    AST_AND_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ctype_i == CT_AND) |=> ((~$past(pred_o) & pred_o) == '0)); // R8
    AST_ANDCM_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ctype_i == CT_ANDCM && dst_a_idx_i != dst_b_idx_i
         && dst_a_idx_i != '0 && dst_b_idx_i != '0 && guard && !tag_eff && rel_true)
        |=> (pred_o[$past(dst_a_idx_i)] && !pred_o[$past(dst_b_idx_i)])); // R10
endmodule

// File: tb/tb_pcmp_unit.sv
module tb_pcmp_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [5:0]  qp_idx_i = '0, dst_a_idx_i = '0, dst_b_idx_i = '0;
    logic [1:0]  src_sel_i = '0;
    logic [3:0]  rel_i = '0;
    logic [2:0]  ctype_i = '0;
    logic [63:0] opnd_a_i = '0, opnd_b_i = '0;
    logic        tag_a_i = 1'b0, tag_b_i = 1'b0;
    logic        fault_o;
    logic [63:0] pred_o;

    int unsigned n_checks = 0, n_fail = 0;
    logic [63:0] exp_pred;
    logic        exp_fault;
    bit          done = 0;

    always #10 clk = ~clk;

    pcmp_unit dut (.*);

    function automatic bit f_rel(logic [63:0] l, logic [63:0] r, logic [3:0] c);
        case (c)
            0: return l == r;
            1: return l != r;
            2: return $signed(l) <  $signed(r);
            3: return $signed(l) <= $signed(r);
            4: return $signed(l) >  $signed(r);
            5: return $signed(l) >= $signed(r);
            6: return l <  r;
            7: return l <= r;
            8: return l >  r;
            default: return l >= r;
        endcase
    endfunction

    // Reference model of one clock edge from the requirement text.
    task automatic model_step();
        logic [63:0] lhs;
        bit tg, rl, g, wa, wb, va, vb;
        exp_fault = 0;
        if (!valid_i) return;                                  // R12
        lhs = (src_sel_i == 0) ? opnd_a_i :
              (src_sel_i == 1) ? {{56{opnd_a_i[7]}}, opnd_a_i[7:0]} : 64'd0; // R4
        tg = tag_b_i | (tag_a_i & (src_sel_i == 0));          // R5
        rl = f_rel(lhs, opnd_b_i, rel_i);                      // R6
        g  = exp_pred[qp_idx_i];
        if (dst_a_idx_i == dst_b_idx_i && (g || ctype_i == 1)) begin
            exp_fault = 1; return;                             // R3
        end
        wa = 0; wb = 0; va = 0; vb = 0;
        if (!g) begin
            if (ctype_i == 1) begin wa = 1; wb = 1; end        // R11
        end else if (ctype_i == 2) begin                       // R8
            if (tg || !rl) begin wa = 1; wb = 1; end
        end else if (ctype_i == 3) begin                       // R9
            if (!tg && rl) begin wa = 1; wb = 1; va = 1; vb = 1; end
        end else if (ctype_i == 4) begin                       // R10
            if (!tg && rl) begin wa = 1; wb = 1; va = 1; end
        end else begin                                         // R7
            wa = 1; wb = 1; va = !tg && rl; vb = !tg && !rl;
        end
        if (wa) exp_pred[dst_a_idx_i] = va;
        if (wb) exp_pred[dst_b_idx_i] = vb;
        exp_pred[0] = 1'b1;                                    // R2
    endtask

    task automatic check(string req);
        n_checks++;
        if (pred_o !== exp_pred) begin
            n_fail++;
            $display("FAIL %s pred actual=%h expected=%h", req, pred_o, exp_pred);
        end
        n_checks++;
        if (fault_o !== exp_fault) begin
            n_fail++;
            $display("FAIL %s fault actual=%b expected=%b", req, fault_o, exp_fault);
        end
    endtask

    task automatic op(bit v, logic [5:0] qp, logic [5:0] da, logic [5:0] db,
                      logic [1:0] s, logic [3:0] r, logic [2:0] t,
                      logic [63:0] a, logic [63:0] b, bit ta, bit tb, string req);
        valid_i = v; qp_idx_i = qp; dst_a_idx_i = da; dst_b_idx_i = db;
        src_sel_i = s; rel_i = r; ctype_i = t; opnd_a_i = a; opnd_b_i = b;
        tag_a_i = ta; tag_b_i = tb;
        model_step();
        @(negedge clk);
        check(req);
    endtask

    function automatic logic [63:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 64'd0;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'hFFFF_FFFF_FFFF_FFFF;
            3: return {$urandom_range(0, 3)} - 64'd1;
            4: return 64'h7FFF_FFFF_FFFF_FFFF;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        exp_pred = 64'h1; exp_fault = 0;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        // R7 normal: 5 < 9 signed -> p1=1, p2=0
        op(1, 0, 1, 2, 0, 2, 0, 64'd5, 64'd9, 0, 0, "R7");
        // R3 equal destinations with guard true
        op(1, 0, 3, 3, 0, 0, 0, 64'd1, 64'd1, 0, 0, "R3");
        // R2 write to index 0 dropped, other destination written (eq false -> p4 gets 1)
        op(1, 0, 0, 4, 0, 0, 0, 64'd1, 64'd2, 0, 0, "R2");
        // R4 immediate 0xFF sign-extends to all ones
        op(1, 0, 5, 6, 1, 0, 0, 64'h00FF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, "R4");
        // R5 tag_a ignored in immediate form
        op(1, 0, 7, 8, 1, 0, 0, 64'h0003, 64'd3, 1, 0, "R5");
        // R5 tag_a honoured in register form -> both cleared
        op(1, 0, 7, 8, 0, 0, 0, 64'd3, 64'd3, 1, 0, "R5");
        // R6 signed vs unsigned at sign boundary
        op(1, 0, 9, 10, 0, 2, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 0, "R6");
        op(1, 0, 11, 12, 0, 6, 0, 64'h8000_0000_0000_0000, 64'd1, 0, 0, "R6");
        // R4 zero form: 0 <=u anything
        op(1, 0, 13, 14, 2, 7, 0, 64'd77, 64'd0, 0, 0, "R4");
        // R11 guard false (p2=0) in unc clears; normal no change
        op(1, 2, 1, 9, 0, 1, 1, 64'd1, 64'd2, 0, 0, "R11");
        op(1, 2, 4, 5, 0, 0, 0, 64'd1, 64'd1, 0, 0, "R11");
        // R3 unc with guard false and equal destinations faults
        op(1, 2, 6, 6, 0, 0, 1, 64'd1, 64'd1, 0, 0, "R3");
        // R9 or-type sets both; R8 and-type clears on tag; R10 andcm
        op(1, 0, 20, 21, 0, 0, 3, 64'd4, 64'd4, 0, 0, "R9");
        op(1, 0, 20, 21, 0, 0, 2, 64'd4, 64'd4, 0, 1, "R8");
        op(1, 0, 22, 23, 0, 1, 4, 64'd4, 64'd5, 0, 0, "R10");
        // R12 strobe low: nothing changes even with fault-worthy inputs
        op(0, 0, 22, 22, 0, 0, 1, 64'd4, 64'd4, 0, 0, "R12");
        for (int i = 0; i < 4000; i++) begin
            op($urandom_range(0, 7) != 0, 6'($urandom_range(0, 9)),
               6'($urandom_range(0, 9)), 6'($urandom_range(0, 9)),
               2'($urandom), 4'($urandom), 3'($urandom),
               pick_val(), pick_val(), $urandom_range(0, 4) == 0,
               $urandom_range(0, 4) == 0, "R7-random");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule